// File: doc/BRIEF.md
# Scatter-gather list walker

The walker reads a chained scatter-gather list from host memory and converts it into a stream of independent data segments for a downstream data mover. Software pulses `start` with the base address of the first list segment. The walker then fetches one 16-byte entry at a time over a single-outstanding memory read port. It decodes each entry into a buffer address, a byte count and a kind. Each data entry with a non-zero length goes out as one address/length descriptor on a valid/ready port. Buffers are never merged or copied.

Lists may span several non-contiguous segments. A link entry redirects fetching to another segment. A tail entry redirects to the final segment and also gives its size in bytes, so the walker knows where the list ends. When the last entry of the final segment has been handled, `done` pulses for one cycle. A malformed entry stops the walk and latches a sticky error together with the entry's position.

Top module: `sg_list_walker`

## Requirements
- R1: While reset is held and right after it, `busy`, `rd_req_valid`, `seg_valid`, `done` and `err` are all low.
- R2: Entry layout, little-endian: bytes 0-7 are the buffer address, bytes 8-11 the length, bytes 12-14 are ignored, and byte 15 is the kind. The kinds are 0 for data, 2 for link and 3 for tail. A data entry with a non-zero length produces exactly one output segment with that address and length.
- R3: Output segments come out in list order. Their lengths add up to the sum of the data entry lengths, for example 4096 + 4096 + 8192 gives 16384 bytes.
- R4: A data entry of length zero produces no output segment, and the walk moves on to the next entry. Every emitted segment has a non-zero length.
- R5: Entries inside a segment are fetched at consecutive 16-byte addresses. After a link entry, the next fetch is at the link's address.
- R6: After a tail entry, the next fetch is at the tail's address. The final segment then holds length/16 entries, with the low 4 length bits ignored. The walk ends after those entries and fetches nothing more. A tail length below 16 ends the walk at once.
- R7: `done` is high for exactly one cycle, in the cycle after the final entry completes. When that entry is a data entry, this is the cycle after its segment is accepted downstream.
- R8: An entry of kind 0, 2 or 3 whose address has bit 1 or bit 0 set stops the walk. It sets the sticky `err` and loads `err_idx` with that entry's 0-based position among all entries fetched since `start`. No `done` follows.
- R9: A kind code other than 0, 2 or 3 stops the walk with an error in the same way. So does a link or tail entry found inside the final segment.
- R10: At most one read is outstanding. No new request is raised until the previous response has arrived. A request held without `rd_req_ready` keeps its address.
- R11: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_len` hold their values.
- R12: `start` has no effect while `busy` is high. A `start` taken while idle clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | AW | Address of the first list segment |
| busy | output | 1 | A walk is in progress |
| rd_req_valid | output | 1 | Entry fetch request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | AW | Address of the entry to fetch |
| rd_rsp_valid | input | 1 | Entry data is returned this cycle |
| rd_rsp_data | input | 128 | The 16-byte entry |
| seg_valid | output | 1 | Output segment valid |
| seg_ready | input | 1 | Data mover accepts the segment |
| seg_addr | output | AW | Buffer address of the segment |
| seg_len | output | LW | Byte count of the segment |
| done | output | 1 | One-cycle pulse when the list is finished |
| err | output | 1 | Sticky malformed-entry flag |
| err_idx | output | IW | Position of the offending entry |

## Verification
Properties check the cycle-level handshake rules on every cycle: a stalled segment is held, a pending request keeps its address, no request goes out while a response is owed, emitted segments are non-zero and aligned, `done` is a single pulse that coincides with idle, and a rising error always means the walk has stopped. Only the bench's list scenarios can show the list semantics. These are that the fetch addresses follow links and tails, that the final segment is counted correctly, that lengths add up, that zero-length entries are skipped, that `err_idx` points at the right entry, and that a `start` issued mid-walk is ignored.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int ENTRY_BITS  = 128;
    localparam int ENTRY_BYTES = ENTRY_BITS / 8;

    localparam logic [7:0] KIND_DATA = 8'h00;
    localparam logic [7:0] KIND_LINK = 8'h02;
    localparam logic [7:0] KIND_TAIL = 8'h03;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_WAIT  = 2'd2,
        S_EMIT  = 2'd3
    } sgw_state_e;
endpackage

// File: rtl/sgw_entry_decode.sv
module sgw_entry_decode
    import sgw_pkg::*;
#(
    parameter int AW = 64,
    parameter int LW = 32
) (
    input  logic [ENTRY_BITS-1:0] raw,
    input  logic                  in_tail,
    output logic [AW-1:0]         addr,
    output logic [LW-1:0]         len,
    output logic                  is_data,
    output logic                  is_link,
    output logic                  is_tail,
    output logic                  bad
);
    logic [7:0] kind;
    logic       misalign;
    logic       known;
    logic       unused_rsv;

    assign kind       = raw[127:120];
    assign addr       = raw[AW-1:0];
    assign len        = raw[64 +: LW];
    assign unused_rsv = ^raw[119:96];

    // Address bits beyond AW are dropped when the address width is narrowed.
    if (AW < 64) begin : g_addr_trim
        logic unused_hi;
        assign unused_hi = ^raw[63:AW];
    end
    if (LW < 32) begin : g_len_trim
        logic unused_len_hi;
        assign unused_len_hi = ^raw[95:64+LW];
    end

    assign is_data  = (kind == KIND_DATA);
    assign is_link  = (kind == KIND_LINK);
    assign is_tail  = (kind == KIND_TAIL);
    assign known    = is_data | is_link | is_tail;
    assign misalign = |addr[1:0];
    // R8, R9: misalignment, unknown kind, or a chain entry inside the final segment
    assign bad      = misalign | ~known | (in_tail & (is_link | is_tail));
endmodule

// File: rtl/sgw_core.sv
module sgw_core
    import sgw_pkg::*;
#(
    parameter int AW = 64,
    parameter int LW = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] dec_addr,
    input  logic [LW-1:0] dec_len,
    input  logic          dec_data,
    input  logic          dec_link,
    input  logic          dec_bad,
    output logic          in_tail,
    output logic          busy,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    output logic [AW-1:0] rd_req_addr,
    input  logic          rd_rsp_valid,
    output logic          seg_valid,
    input  logic          seg_ready,
    output logic [AW-1:0] seg_addr,
    output logic [LW-1:0] seg_len,
    output logic          done,
    output logic          err,
    output logic [IW-1:0] err_idx
);
    localparam int CW = LW - 4;   // entry count of the final segment

    typedef struct packed {
        sgw_state_e    st;
        logic [AW-1:0] ptr;
        logic          tail;
        logic [CW-1:0] remain;
        logic [IW-1:0] idx;
        logic [AW-1:0] oaddr;
        logic [LW-1:0] olen;
        logic          done;
        logic          err;
        logic [IW-1:0] eidx;
    } core_t;

    core_t q, d;
    logic  step;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        step   = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.ptr    = start_addr;
                    d.tail   = 1'b0;
                    d.remain = '0;
                    d.idx    = '0;
                    d.err    = 1'b0;
                    d.eidx   = '0;
                    d.st     = S_FETCH;
                end
            end
            S_FETCH: begin
                if (rd_req_ready) d.st = S_WAIT;
            end
            S_WAIT: begin
                if (rd_rsp_valid) begin
                    if (dec_bad) begin
                        d.err  = 1'b1;
                        d.eidx = q.idx;
                        d.st   = S_IDLE;
                    end else if (dec_data) begin
                        if (dec_len != '0) begin
                            d.oaddr = dec_addr;
                            d.olen  = dec_len;
                            d.st    = S_EMIT;
                        end else begin
                            step = 1'b1;
                        end
                    end else if (dec_link) begin
                        d.ptr = dec_addr;
                        d.idx = q.idx + 1'b1;
                        d.st  = S_FETCH;
                    end else begin
                        d.ptr    = dec_addr;
                        d.tail   = 1'b1;
                        d.remain = dec_len[LW-1:4];
                        d.idx    = q.idx + 1'b1;
                        if (dec_len[LW-1:4] == '0) begin
                            d.done = 1'b1;
                            d.st   = S_IDLE;
                        end else begin
                            d.st = S_FETCH;
                        end
                    end
                end
            end
            S_EMIT: begin
                if (seg_ready) step = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase

        // Move on to the next entry of the current segment.
        if (step) begin
            d.idx = q.idx + 1'b1;
            d.ptr = q.ptr + AW'(ENTRY_BYTES);
            d.st  = S_FETCH;
            if (q.tail) begin
                d.remain = q.remain - 1'b1;
                if (q.remain == CW'(1)) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_tail      = q.tail;
    assign busy         = (q.st != S_IDLE);
    assign rd_req_valid = (q.st == S_FETCH);
    assign rd_req_addr  = q.ptr;
    assign seg_valid    = (q.st == S_EMIT);
    assign seg_addr     = q.oaddr;
    assign seg_len      = q.olen;
    assign done         = q.done;
    assign err          = q.err;
    assign err_idx      = q.eidx;

    // Tracks an accepted read whose response has not yet come back.
    logic pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                            pend_q <= 1'b0;
        else if (rd_req_valid && rd_req_ready) pend_q <= 1'b1;
        else if (rd_rsp_valid)                 pend_q <= 1'b0;
    end

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !rd_req_valid);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
    assert_seg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));
    assert_seg_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0 && seg_addr[1:0] == 2'b00));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err));
    assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker
    import sgw_pkg::*;
#(
    parameter int AW = 64,
    parameter int LW = 32,
    parameter int IW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [AW-1:0]         start_addr,
    output logic                  busy,
    output logic                  rd_req_valid,
    input  logic                  rd_req_ready,
    output logic [AW-1:0]         rd_req_addr,
    input  logic                  rd_rsp_valid,
    input  logic [ENTRY_BITS-1:0] rd_rsp_data,
    output logic                  seg_valid,
    input  logic                  seg_ready,
    output logic [AW-1:0]         seg_addr,
    output logic [LW-1:0]         seg_len,
    output logic                  done,
    output logic                  err,
    output logic [IW-1:0]         err_idx
);
    logic [AW-1:0] dec_addr;
    logic [LW-1:0] dec_len;
    logic          dec_data;
    logic          dec_link;
    logic          dec_tail;
    logic          dec_bad;
    logic          in_tail;
    logic          unused_tail;

    assign unused_tail = dec_tail;

    sgw_entry_decode #(.AW(AW), .LW(LW)) u_dec (
        .raw     (rd_rsp_data),
        .in_tail (in_tail),
        .addr    (dec_addr),
        .len     (dec_len),
        .is_data (dec_data),
        .is_link (dec_link),
        .is_tail (dec_tail),
        .bad     (dec_bad)
    );

    sgw_core #(.AW(AW), .LW(LW), .IW(IW)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_addr   (start_addr),
        .dec_addr     (dec_addr),
        .dec_len      (dec_len),
        .dec_data     (dec_data),
        .dec_link     (dec_link),
        .dec_bad      (dec_bad),
        .in_tail      (in_tail),
        .busy         (busy),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .seg_valid    (seg_valid),
        .seg_ready    (seg_ready),
        .seg_addr     (seg_addr),
        .seg_len      (seg_len),
        .done         (done),
        .err          (err),
        .err_idx      (err_idx)
    );
endmodule

// File: tb/sim_sg_list_walker.sv
`timescale 1ns/1ps
module sim_sg_list_walker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [63:0]  start_addr = '0;
    logic         busy, rd_req_valid, seg_valid, done, err;
    logic         rd_req_ready = 1'b0;
    logic [63:0]  rd_req_addr, seg_addr;
    logic         rd_rsp_valid = 1'b0;
    logic [127:0] rd_rsp_data = '0;
    logic         seg_ready = 1'b0;
    logic [31:0]  seg_len;
    logic [15:0]  err_idx;

    always #2 clk = ~clk;   // 250 MHz

    sg_list_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .busy(busy), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .done(done), .err(err), .err_idx(err_idx)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Host memory model: 64 entries of 16 bytes.
    logic [127:0] mem [64];
    task automatic put(input int slot, input logic [7:0] kind,
                       input logic [63:0] a, input logic [31:0] l);
        mem[slot] = {kind, 24'h0, l, a};
    endtask
    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = {8'hFF, 24'h0, 32'h0, 64'h0};
    endtask

    // Recorders
    logic [63:0] got_addr [32];
    logic [31:0] got_len  [32];
    logic [63:0] fetch    [32];
    int n_got = 0, n_fetch = 0, done_cnt = 0, cyc = 0, hs_cyc = -10, done_cyc = -10;
    int rdy_mode = 0;
    bit pend = 1'b0;
    int lat = 0;
    logic [63:0] paddr = '0;
    bit prev_stall = 1'b0;
    logic [63:0] p_addr = '0;
    logic [31:0] p_len = '0;

    always @(negedge clk) begin
        cyc++;
        if (prev_stall)
            chk(seg_valid && seg_addr == p_addr && seg_len == p_len, "R11",
                "stalled segment changed", seg_addr, p_addr);
        seg_ready  = (rdy_mode == 0) || (cyc % 4 != 0);
        prev_stall = seg_valid && !seg_ready;
        p_addr     = seg_addr;
        p_len      = seg_len;
        if (seg_valid && seg_ready) begin
            if (n_got < 32) begin
                got_addr[n_got] = seg_addr;
                got_len[n_got]  = seg_len;
            end
            n_got++;
            hs_cyc = cyc;
        end
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
        rd_rsp_valid = 1'b0;
        if (rd_req_valid)
            chk(!pend, "R10", "request while response owed", 64'(rd_req_valid), 64'd0);
        if (pend) begin
            if (lat == 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem[paddr[9:4]];
                pend = 1'b0;
            end else begin
                lat--;
            end
        end
        rd_req_ready = (cyc % 3 != 1);
        if (rd_req_valid && rd_req_ready) begin
            if (n_fetch < 32) fetch[n_fetch] = rd_req_addr;
            n_fetch++;
            pend  = 1'b1;
            lat   = n_fetch % 2;
            paddr = rd_req_addr;
        end
    end

    task automatic run(input logic [63:0] base, input bit poke);
        n_got = 0; n_fetch = 0; done_cnt = 0; hs_cyc = -10; done_cyc = -10;
        @(negedge clk);
        start = 1'b1; start_addr = base;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b0, "R12", "err not cleared by start", 64'(err), 64'd0);
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; start_addr = 64'h300;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 3000 && busy; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Main list, in walk order: slot, kind, address, length.
    localparam int NROW = 8;
    localparam logic [111:0] TAB [NROW] = '{
        {8'd0,  8'd0, 64'h1000, 32'd4096},
        {8'd1,  8'd0, 64'h2004, 32'd0},
        {8'd2,  8'd2, 64'h0100, 32'd0},
        {8'd16, 8'd0, 64'h3008, 32'd4096},
        {8'd17, 8'd3, 64'h0200, 32'h33},
        {8'd32, 8'd0, 64'h5000, 32'd8192},
        {8'd33, 8'd0, 64'h7FFC, 32'd5},
        {8'd34, 8'd0, 64'h9000, 32'd12}
    };

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ne;
        longint sum;
        clear_mem();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy, "R1", "busy", 64'(busy), 0);
        chk(!rd_req_valid && !seg_valid, "R1", "valids", 64'({rd_req_valid, seg_valid}), 0);
        chk(!done && !err, "R1", "done/err", 64'({done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_req_valid && !seg_valid, "R1", "after release", 64'(busy), 0);

        // Main chained list with backpressure and a start poke mid-walk (R12).
        for (int i = 0; i < NROW; i++)
            put(int'(TAB[i][111:104]), TAB[i][103:96], TAB[i][95:32], TAB[i][31:0]);
        put(35, 8'h01, 64'h11, 32'd4);   // must never be fetched
        rdy_mode = 1;
        run(64'h0, 1'b1);
        chk(n_fetch == NROW, "R6", "fetch count", 64'(n_fetch), 64'(NROW));
        for (int i = 0; i < NROW && i < n_fetch; i++)
            chk(fetch[i] == 64'(TAB[i][111:104]) * 16, "R5", "fetch address",
                fetch[i], 64'(TAB[i][111:104]) * 16);
        ne = 0; sum = 0;
        for (int i = 0; i < NROW; i++) begin
            if (TAB[i][103:96] == 8'd0 && TAB[i][31:0] != 0) begin
                if (ne < n_got) begin
                    chk(got_addr[ne] == TAB[i][95:32], "R2", "segment address",
                        got_addr[ne], TAB[i][95:32]);
                    chk(got_len[ne] == TAB[i][31:0], "R3", "segment length",
                        64'(got_len[ne]), 64'(TAB[i][31:0]));
                end
                sum += longint'(TAB[i][31:0]);
                ne++;
            end
        end
        chk(n_got == ne, "R4", "segments emitted (zero length skipped)", 64'(n_got), 64'(ne));
        begin
            longint gs = 0;
            for (int i = 0; i < n_got && i < 32; i++) gs += longint'(got_len[i]);
            chk(gs == sum && sum == 16401, "R3", "total bytes", 64'(gs), 64'(sum));
        end
        chk(done_cnt == 1, "R7", "done pulses", 64'(done_cnt), 1);
        chk(done_cyc == hs_cyc + 1, "R7", "done timing", 64'(done_cyc), 64'(hs_cyc + 1));
        chk(!err && !busy, "R12", "poke ignored, clean end", 64'({err, busy}), 0);

        // R8: misaligned address in the second entry
        clear_mem(); rdy_mode = 0;
        put(0, 8'h00, 64'h4000, 32'd64);
        put(1, 8'h00, 64'h4006, 32'd8);
        run(64'h0, 1'b0);
        chk(err && err_idx == 16'd1, "R8", "misaligned err_idx", 64'(err_idx), 1);
        chk(n_got == 1 && done_cnt == 0 && n_fetch == 2, "R8", "stop after error",
            64'(n_got), 1);
        chk(!busy, "R8", "idle after error", 64'(busy), 0);

        // R9: unknown kind code
        clear_mem();
        put(0, 8'h01, 64'h0010, 32'd16);
        run(64'h0, 1'b0);
        chk(err && err_idx == 16'd0 && n_got == 0, "R9", "unknown kind", 64'(err_idx), 0);

        // R9: link entry inside the final segment
        clear_mem();
        put(0, 8'h03, 64'h0280, 32'd32);
        put(40, 8'h02, 64'h0000, 32'd0);
        run(64'h0, 1'b0);
        chk(err && err_idx == 16'd1 && done_cnt == 0, "R9", "chain in final segment",
            64'(err_idx), 1);

        // R6: empty final segment ends at once; R12: err cleared by new start
        clear_mem();
        put(0, 8'h00, 64'h0100, 32'd8);
        put(1, 8'h03, 64'h0380, 32'd0);
        run(64'h0, 1'b0);
        chk(n_fetch == 2 && n_got == 1, "R6", "empty final segment", 64'(n_fetch), 2);
        chk(done_cnt == 1 && !err, "R6", "done after empty tail", 64'(done_cnt), 1);
        chk(got_addr[0] == 64'h100 && got_len[0] == 32'd8, "R2", "single segment",
            got_addr[0], 64'h100);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule